// File: doc/BRIEF.md
# Shared Address CAM With Port Masks

This block decides whether a 48-bit station address is allowed on a given port of a multiport repeater. It holds a pool of shared address entries, plus two private entries for each port. Software loads the shared entries one byte at a time through a byte-wide register interface. Each shared entry carries a port ownership mask and a separate valid bit. A private entry can be written by software, or it can be captured from the source address of a received packet while learning is enabled for its port.

The surrounding repeater logic presents an address (source or destination, once fully received) together with the port it relates to. One cycle later the block answers with a single hit bit. Frame parsing, CRC computation and the scrambling of rejected data are done elsewhere. At the end of each packet the block is only told the port, the captured source address and whether the CRC was good.

Top module: `addr_guard_cam`

## Requirements
- R1: After reset every shared valid bit is 0, every learn-enable bit is 0, no private slot takes part in matching, and `hit` and `hit_valid` are 0. Every shared byte pointer reads as 1, so a high-mask read (space 2) returns 8'h20 for an entry whose high mask bits are clear.
- R2: In space 0, `reg_idx` selects a shared entry, and the byte reached is the one named by that entry's pointer (1 = least significant byte, 6 = most significant). The pointer advances by one after each read or write strobe in space 0 and wraps from 6 back to 1, so six writes load a full address, least significant byte first.
- R3: Writing space 2 puts `reg_wdata[4:0]` into the mask bits for ports 8 to 12 and loads the pointer from `reg_wdata[7:5]`; a value of 0 or 7 loads 1 instead. Reading space 2 returns {pointer, ports 12..8}. Writing space 1 sets the mask bits for ports 7 to 0 and leaves the pointer untouched.
- R4: Space 3 holds the valid bits. `reg_idx[1:0]` = g selects the group, and bit b is the valid bit of shared entry 8g+b. An entry whose valid bit is 0 never matches.
- R5: A valid shared entry matches a compare only when its address is equal to the compare address and its mask bit for the compare port is set. One entry may serve several ports.
- R6: Space 4 (slot 0) and space 5 (slot 1) reach the private entries. `reg_idx` selects the port and `reg_byte` selects the byte (0 = least significant). A slot takes part in matching after any write or learn to it, and it matches only for its own port.
- R7: A learn event for a port with learning enabled and a good CRC stores the source address in one of the port's two slots, unless either valid slot already holds that address. A per-port replacement pointer, starting at slot 0, chooses the slot and then toggles. A bad CRC, or learning disabled, leaves the slots unchanged. Space 6 holds the learn-enable bits, with group `reg_idx[0]` and bit b standing for port 8*group+b.
- R8: While learning is enabled for a port, reads of that port's private slots return 0 and writes to them are ignored.
- R9: `hit_valid` is high exactly one cycle after each `cmp_valid` strobe. `hit` then shows the result, judged against the contents as they were before any register write in the same cycle, and `hit` holds its value until the next strobe.
- R10: A compare on a port number of 13 or above never hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (advances a shared pointer in space 0) |
| reg_space | input | 3 | Register space: 0 shared data, 1 mask low, 2 mask high/pointer, 3 valid, 4/5 private slots, 6 learn enable |
| reg_idx | input | 5 | Entry, port or group index |
| reg_byte | input | 3 | Byte index for private slot access |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the current space and index |
| cmp_valid | input | 1 | Compare strobe |
| cmp_port | input | 4 | Port the compare address relates to |
| cmp_addr | input | 48 | Address to compare |
| hit_valid | output | 1 | Result strobe, one cycle after the compare |
| hit | output | 1 | Match result, held between compares |
| learn_valid | input | 1 | End-of-packet learn event |
| learn_port | input | 4 | Port that received the packet |
| learn_addr | input | 48 | Source address of the packet |
| learn_crc_ok | input | 1 | Packet ended with a good CRC |

## Verification
The hardest situation to reach from the ports is the choice between the two private slots. It only shows after several good-CRC learn events on one port, including one whose address is already stored. The stimulus learns four different addresses and one repeat, then probes each address in turn. The result must show that the repeat left the replacement pointer alone and that the oldest slot was the one overwritten. The wrap of the byte pointer is reached by mixing read strobes with explicit pointer loads, and every later byte access is checked against that position.

// File: rtl/agc_pkg.sv
package agc_pkg;
  typedef enum logic [2:0] {
    SP_SH_DATA = 3'd0,
    SP_MASK_LO = 3'd1,
    SP_MASK_HI = 3'd2,
    SP_VALID   = 3'd3,
    SP_PRIV0   = 3'd4,
    SP_PRIV1   = 3'd5,
    SP_LEARN   = 3'd6,
    SP_NONE    = 3'd7
  } space_e;

  localparam int BYTE_W   = 8;
  localparam int PTR_W    = 3;
  localparam int PTR_MIN  = 1;
endpackage

// File: rtl/agc_shared_bank.sv
module agc_shared_bank
  import agc_pkg::*;
#(
  parameter int N_ENT   = 32,
  parameter int N_PORTS = 13,
  parameter int ADDR_W  = 48,
  parameter int IDX_W   = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                acc_wr,
  input  logic                acc_rd,
  input  space_e              acc_space,
  input  logic [IDX_W-1:0]    acc_idx,
  input  logic [BYTE_W-1:0]   wdata,
  output logic [BYTE_W-1:0]   rdata,
  input  logic [N_PORTS-1:0]  cmp_oh,
  input  logic [ADDR_W-1:0]   cmp_addr,
  output logic                hit
);
  localparam int N_BYTES = ADDR_W / BYTE_W;
  localparam int N_VGRP  = N_ENT / BYTE_W;
  localparam int ENT_W   = $clog2(N_ENT);
  localparam int VG_W    = (N_VGRP > 1) ? $clog2(N_VGRP) : 1;

  logic [ADDR_W-1:0]  ent_a  [N_ENT];
  logic [N_PORTS-1:0] mask_a [N_ENT];
  logic [PTR_W-1:0]   ptr_a  [N_ENT];
  logic [N_ENT-1:0]   valid_a;
  logic [N_ENT-1:0]   match_a;

  logic access_data, wr_lo, wr_hi, wr_valid;
  logic ptr_load_ok;

  assign access_data = (acc_wr || acc_rd) && (acc_space == SP_SH_DATA);
  assign wr_lo       = acc_wr && (acc_space == SP_MASK_LO);
  assign wr_hi       = acc_wr && (acc_space == SP_MASK_HI);
  assign wr_valid    = acc_wr && (acc_space == SP_VALID);
  assign ptr_load_ok = (wdata[7:5] != 3'd0) && (wdata[7:5] != 3'd7);

  for (genvar e = 0; e < N_ENT; e++) begin : g_ent
    logic               sel;
    logic [ADDR_W-1:0]  ent_r;
    logic [N_PORTS-1:0] mask_r, mask_d;
    logic [PTR_W-1:0]   ptr_r, ptr_d;
    logic               vld_r, vld_d;
    logic               byte_we;

    assign sel     = (acc_idx == IDX_W'(e));
    assign byte_we = acc_wr && (acc_space == SP_SH_DATA) && sel;

    // next-state
    always_comb begin
      mask_d = mask_r;
      for (int p = 0; p < N_PORTS; p++) begin
        if (p < BYTE_W) begin
          if (wr_lo && sel) mask_d[p] = wdata[p % BYTE_W];
        end else begin
          if (wr_hi && sel) mask_d[p] = wdata[p % BYTE_W];
        end
      end
    end

    always_comb begin
      ptr_d = ptr_r;
      if (wr_hi && sel) begin
        ptr_d = ptr_load_ok ? wdata[7:5] : PTR_W'(PTR_MIN);
      end else if (access_data && sel) begin
        ptr_d = (ptr_r == PTR_W'(N_BYTES)) ? PTR_W'(PTR_MIN) : ptr_r + 1'b1;
      end
    end

    always_comb begin
      vld_d = vld_r;
      if (wr_valid && (acc_idx[VG_W-1:0] == VG_W'(e / BYTE_W)))
        vld_d = wdata[e % BYTE_W];
    end

    // registers with reset
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mask_r <= '0;
        ptr_r  <= PTR_W'(PTR_MIN);
        vld_r  <= 1'b0;
      end else begin
        mask_r <= mask_d;
        ptr_r  <= ptr_d;
        vld_r  <= vld_d;
      end
    end

    // address storage, no reset
    always_ff @(posedge clk) begin
      if (byte_we) ent_r[BYTE_W*(int'(ptr_r)-1) +: BYTE_W] <= wdata;
    end

    assign ent_a[e]   = ent_r;
    assign mask_a[e]  = mask_r;
    assign ptr_a[e]   = ptr_r;
    assign valid_a[e] = vld_r;
    assign match_a[e] = vld_r && (ent_r == cmp_addr) && (|(mask_r & cmp_oh));
  end

  assign hit = |match_a;

  // read path
  logic [ENT_W-1:0]  ridx;
  logic              ridx_ok;
  logic [15:0]       mask_pad;

  assign ridx    = acc_idx[ENT_W-1:0];
  assign ridx_ok = (int'(acc_idx) < N_ENT);

  always_comb begin
    mask_pad = '0;
    mask_pad[N_PORTS-1:0] = mask_a[ridx];
  end

  always_comb begin
    rdata = '0;
    unique case (acc_space)
      SP_SH_DATA: if (ridx_ok) rdata = ent_a[ridx][BYTE_W*(int'(ptr_a[ridx])-1) +: BYTE_W];
      SP_MASK_LO: if (ridx_ok) rdata = mask_pad[7:0];
      SP_MASK_HI: if (ridx_ok) rdata = {ptr_a[ridx], mask_pad[12:8]};
      SP_VALID:   if (int'(acc_idx) < N_VGRP)
                    rdata = valid_a[BYTE_W*int'(acc_idx[VG_W-1:0]) +: BYTE_W];
      default:    rdata = '0;
    endcase
  end
endmodule

// File: rtl/agc_private_bank.sv
module agc_private_bank
  import agc_pkg::*;
#(
  parameter int N_PORTS = 13,
  parameter int ADDR_W  = 48,
  parameter int PORT_W  = 4,
  parameter int IDX_W   = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                acc_wr,
  input  space_e              acc_space,
  input  logic [IDX_W-1:0]    acc_idx,
  input  logic [2:0]          acc_byte,
  input  logic [BYTE_W-1:0]   wdata,
  output logic [BYTE_W-1:0]   rdata,
  input  logic                learn_valid,
  input  logic [PORT_W-1:0]   learn_port,
  input  logic [ADDR_W-1:0]   learn_addr,
  input  logic                learn_crc_ok,
  input  logic [N_PORTS-1:0]  cmp_oh,
  input  logic [ADDR_W-1:0]   cmp_addr,
  output logic                hit,
  output logic [N_PORTS-1:0]  learn_en
);
  localparam int N_SLOT  = 2;
  localparam int N_BYTES = ADDR_W / BYTE_W;

  logic [ADDR_W-1:0] slot_a [N_SLOT*N_PORTS];
  logic [N_PORTS-1:0] match_a;
  logic byte_ok;

  assign byte_ok = (int'(acc_byte) < N_BYTES);

  for (genvar p = 0; p < N_PORTS; p++) begin : g_port
    logic              sel, len_r, len_d, repl_r, repl_d;
    logic [N_SLOT-1:0] pv_r, pv_d, cwe, hold;
    logic [ADDR_W-1:0] slot_r [N_SLOT];
    logic              take;

    assign sel = (acc_idx == IDX_W'(p));

    for (genvar s = 0; s < N_SLOT; s++) begin : g_slot
      assign cwe[s]  = acc_wr && sel && !len_r && byte_ok &&
                       (acc_space == space_e'(int'(SP_PRIV0) + s));
      assign hold[s] = pv_r[s] && (slot_r[s] == learn_addr);
      assign slot_a[p*N_SLOT+s] = slot_r[s];
    end

    assign take = learn_valid && learn_crc_ok && len_r &&
                  (learn_port == PORT_W'(p)) && !(|hold);

    // next-state
    always_comb begin
      len_d  = len_r;
      pv_d   = pv_r | cwe;
      repl_d = repl_r;
      if (acc_wr && (acc_space == SP_LEARN) && (acc_idx == IDX_W'(p / BYTE_W)))
        len_d = wdata[p % BYTE_W];
      if (take) begin
        pv_d[repl_r] = 1'b1;
        repl_d       = ~repl_r;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        len_r  <= 1'b0;
        pv_r   <= '0;
        repl_r <= 1'b0;
      end else begin
        len_r  <= len_d;
        pv_r   <= pv_d;
        repl_r <= repl_d;
      end
    end

    // slot storage, no reset
    always_ff @(posedge clk) begin
      for (int s = 0; s < N_SLOT; s++) begin
        if (take && (int'(repl_r) == s))
          slot_r[s] <= learn_addr;
        else if (cwe[s])
          slot_r[s][BYTE_W*int'(acc_byte) +: BYTE_W] <= wdata;
      end
    end

    assign learn_en[p] = len_r;
    assign match_a[p]  = cmp_oh[p] &&
                         ((pv_r[0] && (slot_r[0] == cmp_addr)) ||
                          (pv_r[1] && (slot_r[1] == cmp_addr)));
  end

  assign hit = |match_a;

  // read path
  logic [PORT_W-1:0] pidx;
  logic              pidx_ok;
  logic [15:0]       len_pad;
  int                sidx;

  assign pidx    = acc_idx[PORT_W-1:0];
  assign pidx_ok = (int'(acc_idx) < N_PORTS);
  assign sidx    = int'(pidx) * N_SLOT + ((acc_space == SP_PRIV1) ? 1 : 0);

  always_comb begin
    len_pad = '0;
    len_pad[N_PORTS-1:0] = learn_en;
  end

  always_comb begin
    rdata = '0;
    unique case (acc_space)
      SP_PRIV0, SP_PRIV1:
        if (pidx_ok && byte_ok && !len_pad[pidx])
          rdata = slot_a[sidx][BYTE_W*int'(acc_byte) +: BYTE_W];
      SP_LEARN:
        rdata = acc_idx[0] ? len_pad[15:8] : len_pad[7:0];
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/addr_guard_cam.sv
module addr_guard_cam
  import agc_pkg::*;
#(
  parameter int N_ENT   = 32,
  parameter int N_PORTS = 13,
  parameter int ADDR_W  = 48,
  parameter int PORT_W  = 4,
  parameter int IDX_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_space,
  input  logic [IDX_W-1:0]  reg_idx,
  input  logic [2:0]        reg_byte,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              cmp_valid,
  input  logic [PORT_W-1:0] cmp_port,
  input  logic [ADDR_W-1:0] cmp_addr,
  output logic              hit_valid,
  output logic              hit,
  input  logic              learn_valid,
  input  logic [PORT_W-1:0] learn_port,
  input  logic [ADDR_W-1:0] learn_addr,
  input  logic              learn_crc_ok
);
  // reset synchronizer: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  space_e             space;
  logic [N_PORTS-1:0] cmp_oh;
  logic [7:0]         sh_rdata, pv_rdata;
  logic               sh_hit, pv_hit;
  logic [N_PORTS-1:0] learn_en_w;

  assign space = space_e'(reg_space);

  always_comb begin
    for (int p = 0; p < N_PORTS; p++) cmp_oh[p] = (cmp_port == PORT_W'(p));
  end

  agc_shared_bank #(
    .N_ENT(N_ENT), .N_PORTS(N_PORTS), .ADDR_W(ADDR_W), .IDX_W(IDX_W)
  ) u_shared (
    .clk(clk), .rst_n(rst_core_n),
    .acc_wr(reg_wr), .acc_rd(reg_rd), .acc_space(space), .acc_idx(reg_idx),
    .wdata(reg_wdata), .rdata(sh_rdata),
    .cmp_oh(cmp_oh), .cmp_addr(cmp_addr), .hit(sh_hit)
  );

  agc_private_bank #(
    .N_PORTS(N_PORTS), .ADDR_W(ADDR_W), .PORT_W(PORT_W), .IDX_W(IDX_W)
  ) u_private (
    .clk(clk), .rst_n(rst_core_n),
    .acc_wr(reg_wr), .acc_space(space), .acc_idx(reg_idx), .acc_byte(reg_byte),
    .wdata(reg_wdata), .rdata(pv_rdata),
    .learn_valid(learn_valid), .learn_port(learn_port),
    .learn_addr(learn_addr), .learn_crc_ok(learn_crc_ok),
    .cmp_oh(cmp_oh), .cmp_addr(cmp_addr), .hit(pv_hit), .learn_en(learn_en_w)
  );

  always_comb begin
    unique case (space)
      SP_SH_DATA, SP_MASK_LO, SP_MASK_HI, SP_VALID: reg_rdata = sh_rdata;
      SP_PRIV0, SP_PRIV1, SP_LEARN:                 reg_rdata = pv_rdata;
      default:                                      reg_rdata = '0;
    endcase
  end

  // result register
  logic hit_valid_d, hit_d, hit_valid_q, hit_q;

  always_comb begin
    hit_valid_d = cmp_valid;
    hit_d       = hit_q;
    if (cmp_valid) hit_d = sh_hit || pv_hit;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      hit_valid_q <= 1'b0;
      hit_q       <= 1'b0;
    end else begin
      hit_valid_q <= hit_valid_d;
      hit_q       <= hit_d;
    end
  end

  assign hit_valid = hit_valid_q;
  assign hit       = hit_q;
endmodule

// File: rtl/agc_checker.sv
module agc_checker #(
  parameter int N_PORTS = 13,
  parameter int PORT_W  = 4,
  parameter int IDX_W   = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_rd,
  input logic [2:0]        reg_space,
  input logic [IDX_W-1:0]  reg_idx,
  input logic [7:0]        reg_rdata,
  input logic              cmp_valid,
  input logic [PORT_W-1:0] cmp_port,
  input logic              hit_valid,
  input logic              hit,
  input logic [N_PORTS-1:0] learn_en
);
  logic hidden_port;
  assign hidden_port = (int'(reg_idx) < N_PORTS) &&
                       (((learn_en >> reg_idx) & N_PORTS'(1)) != '0);

  AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid |=> hit_valid);                                              // R9
  AST_RESULT_CAUSED: assert property (@(posedge clk) disable iff (!rst_n)
    hit_valid |-> $past(cmp_valid));                                       // R9
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_valid |=> $stable(hit));                                          // R9
  AST_FOREIGN_PORT_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && (int'(cmp_port) >= N_PORTS)) |=> !hit);                  // R10
  AST_POINTER_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_space == 3'd2 && int'(reg_idx) < 32)
      |-> (reg_rdata[7:5] != 3'd0 && reg_rdata[7:5] != 3'd7));             // R2
  AST_LEARN_HIDES_SLOTS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && (reg_space == 3'd4 || reg_space == 3'd5) && hidden_port)
      |-> (reg_rdata == 8'h00));                                           // R8
endmodule

bind addr_guard_cam agc_checker #(
  .N_PORTS(N_PORTS), .PORT_W(PORT_W), .IDX_W(IDX_W)
) u_agc_checker (
  .clk(clk), .rst_n(rst_core_n),
  .reg_rd(reg_rd), .reg_space(reg_space), .reg_idx(reg_idx), .reg_rdata(reg_rdata),
  .cmp_valid(cmp_valid), .cmp_port(cmp_port),
  .hit_valid(hit_valid), .hit(hit), .learn_en(learn_en_w)
);

// File: tb/addr_guard_cam_test.sv
`timescale 1ns/1ps
module addr_guard_cam_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr, reg_rd;
  logic [2:0]  reg_space;
  logic [4:0]  reg_idx;
  logic [2:0]  reg_byte;
  logic [7:0]  reg_wdata, reg_rdata;
  logic        cmp_valid;
  logic [3:0]  cmp_port;
  logic [47:0] cmp_addr;
  logic        hit_valid, hit;
  logic        learn_valid, learn_crc_ok;
  logic [3:0]  learn_port;
  logic [47:0] learn_addr;

  int n_checks = 0;
  int n_fail   = 0;

  bit    exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  addr_guard_cam uut (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_space(reg_space), .reg_idx(reg_idx),
    .reg_byte(reg_byte), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cmp_valid(cmp_valid), .cmp_port(cmp_port), .cmp_addr(cmp_addr),
    .hit_valid(hit_valid), .hit(hit),
    .learn_valid(learn_valid), .learn_port(learn_port),
    .learn_addr(learn_addr), .learn_crc_ok(learn_crc_ok)
  );

  localparam logic [47:0] ADR_A = 48'h0011_2233_4455;
  localparam logic [47:0] ADR_B = 48'hA0B1_C2D3_E4F5;
  localparam logic [47:0] ADR_C = 48'h1234_5678_9ABC;
  localparam logic [47:0] ADR_D = 48'h0200_0000_0001;
  localparam logic [47:0] ADR_E = 48'h0200_0000_0002;
  localparam logic [47:0] ADR_F = 48'h0200_0000_00F3;
  localparam logic [47:0] ADR_G = 48'h0200_0000_00C7;
  localparam logic [47:0] ADR_H = 48'h0600_0000_0099;

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] sp, input logic [4:0] idx,
                           input logic [2:0] b, input logic [7:0] d);
    @(negedge clk);
    reg_space = sp; reg_idx = idx; reg_byte = b; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] sp, input logic [4:0] idx,
                          input logic [2:0] b, output logic [7:0] d);
    @(negedge clk);
    reg_space = sp; reg_idx = idx; reg_byte = b; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic read_check(input string tag, input logic [2:0] sp, input logic [4:0] idx,
                            input logic [2:0] b, input logic [7:0] exp);
    logic [7:0] d;
    reg_read(sp, idx, b, d);
    check8(tag, d, exp);
  endtask

  // driver: pushes the expected result, then strobes the compare
  task automatic compare(input logic [3:0] port, input logic [47:0] adr,
                         input bit exp, input string tag);
    @(negedge clk);
    exp_q.push_back(exp); tag_q.push_back(tag);
    cmp_port = port; cmp_addr = adr; cmp_valid = 1'b1;
    @(negedge clk);
    cmp_valid = 1'b0;
  endtask

  task automatic learn(input logic [3:0] port, input logic [47:0] adr, input logic ok);
    @(negedge clk);
    learn_port = port; learn_addr = adr; learn_crc_ok = ok; learn_valid = 1'b1;
    @(negedge clk);
    learn_valid = 1'b0;
  endtask

  task automatic write_shared(input logic [4:0] ent, input logic [47:0] adr);
    for (int b = 0; b < 6; b++) reg_write(3'd0, ent, 3'd0, adr[8*b +: 8]);
  endtask

  task automatic write_priv(input logic [2:0] sp, input logic [4:0] port, input logic [47:0] adr);
    for (int b = 0; b < 6; b++) reg_write(sp, port, 3'(b), adr[8*b +: 8]);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  // monitor: pops expected results as the design produces them
  always @(negedge clk) begin
    if (hit_valid) begin
      n_checks++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R9: result strobe with no compare pending, actual %0b expected none", hit);
      end else begin
        automatic bit    e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (hit !== e) begin
          n_fail++;
          $display("FAIL %s: actual %0b expected %0b", t, hit, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    reg_wr = 0; reg_rd = 0; reg_space = 0; reg_idx = 0; reg_byte = 0; reg_wdata = 0;
    cmp_valid = 0; cmp_port = 0; cmp_addr = 0;
    learn_valid = 0; learn_port = 0; learn_addr = 0; learn_crc_ok = 0;
    repeat (3) @(negedge clk);
    n_checks++;
    if (hit !== 1'b0 || hit_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: actual hit=%0b hit_valid=%0b expected 0 0", hit, hit_valid);
    end
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    read_check("R1 pointer after reset", 3'd2, 5'd0, 3'd0, 8'h20);
    for (int g = 0; g < 4; g++) read_check("R1 valid group", 3'd3, 5'(g), 3'd0, 8'h00);
    read_check("R1 learn enables", 3'd6, 5'd0, 3'd0, 8'h00);
    compare(4'd0, 48'h0, 1'b0, "R1 no match after reset");

    // R2 load entry 3, own port 2; R4 invalid entry never matches
    write_shared(5'd3, ADR_A);
    reg_write(3'd1, 5'd3, 3'd0, 8'h04);
    compare(4'd2, ADR_A, 1'b0, "R4 not yet valid");
    reg_write(3'd3, 5'd0, 3'd0, 8'h08);
    read_check("R4 valid readback", 3'd3, 5'd0, 3'd0, 8'h08);
    compare(4'd2, ADR_A, 1'b1, "R5 owner port hits");
    compare(4'd3, ADR_A, 1'b0, "R5 non-owner misses");
    compare(4'd2, ADR_B, 1'b0, "R5 other address misses");

    // R2 pointer wrap and read advance
    read_check("R2 pointer wrapped to 1", 3'd2, 5'd3, 3'd0, 8'h20);
    read_check("R2 byte 1", 3'd0, 5'd3, 3'd0, 8'h55);
    read_check("R2 byte 2", 3'd0, 5'd3, 3'd0, 8'h44);
    read_check("R2 pointer after reads", 3'd2, 5'd3, 3'd0, 8'h60);

    // R3 explicit pointer load, low mask write keeps pointer
    reg_write(3'd2, 5'd3, 3'd0, 8'hA1);
    read_check("R3 loaded pointer", 3'd2, 5'd3, 3'd0, 8'hA1);
    reg_write(3'd1, 5'd3, 3'd0, 8'h04);
    read_check("R3 low mask keeps pointer", 3'd2, 5'd3, 3'd0, 8'hA1);
    read_check("R3 byte at pointer 5", 3'd0, 5'd3, 3'd0, 8'h11);
    read_check("R2 byte 6", 3'd0, 5'd3, 3'd0, 8'h00);
    read_check("R2 wrap after byte 6", 3'd2, 5'd3, 3'd0, 8'h21);
    reg_write(3'd2, 5'd3, 3'd0, 8'hE0);
    read_check("R3 out-of-range load gives 1", 3'd2, 5'd3, 3'd0, 8'h20);

    // R5 entry 31 shared by ports 0 and 12
    reg_write(3'd2, 5'd31, 3'd0, 8'h30);
    reg_write(3'd1, 5'd31, 3'd0, 8'h01);
    write_shared(5'd31, ADR_B);
    reg_write(3'd3, 5'd3, 3'd0, 8'h80);
    compare(4'd12, ADR_B, 1'b1, "R5 shared port 12");
    compare(4'd0, ADR_B, 1'b1, "R5 shared port 0");
    compare(4'd5, ADR_B, 1'b0, "R5 port outside mask");
    compare(4'd13, ADR_B, 1'b0, "R10 port 13");
    compare(4'd15, ADR_B, 1'b0, "R10 port 15");
    reg_write(3'd3, 5'd0, 3'd0, 8'h00);
    compare(4'd2, ADR_A, 1'b0, "R4 cleared valid");

    // R6 private slots
    write_priv(3'd4, 5'd5, ADR_C);
    compare(4'd5, ADR_C, 1'b1, "R6 own port hits");
    compare(4'd6, ADR_C, 1'b0, "R6 other port misses");
    read_check("R6 private readback", 3'd4, 5'd5, 3'd2, 8'h78);

    // R7 learning
    reg_write(3'd6, 5'd0, 3'd0, 8'h80);
    read_check("R7 learn enable readback", 3'd6, 5'd0, 3'd0, 8'h80);
    learn(4'd7, ADR_D, 1'b0);
    compare(4'd7, ADR_D, 1'b0, "R7 bad CRC not learned");
    learn(4'd7, ADR_D, 1'b1);
    compare(4'd7, ADR_D, 1'b1, "R7 learned into slot 0");
    learn(4'd7, ADR_E, 1'b1);
    compare(4'd7, ADR_D, 1'b1, "R7 slot 0 kept");
    compare(4'd7, ADR_E, 1'b1, "R7 learned into slot 1");
    learn(4'd7, ADR_F, 1'b1);
    compare(4'd7, ADR_D, 1'b0, "R7 slot 0 replaced");
    compare(4'd7, ADR_F, 1'b1, "R7 new in slot 0");
    learn(4'd7, ADR_E, 1'b1);
    learn(4'd7, ADR_G, 1'b1);
    compare(4'd7, ADR_E, 1'b0, "R7 repeat kept pointer, slot 1 replaced");
    compare(4'd7, ADR_F, 1'b1, "R7 slot 0 survives");
    compare(4'd7, ADR_G, 1'b1, "R7 new in slot 1");
    learn(4'd5, ADR_H, 1'b1);
    compare(4'd5, ADR_H, 1'b0, "R7 learning disabled port");
    compare(4'd5, ADR_C, 1'b1, "R7 disabled port unchanged");

    // R8 hidden slots while learning
    read_check("R8 read hidden", 3'd4, 5'd7, 3'd0, 8'h00);
    reg_write(3'd5, 5'd7, 3'd0, 8'h55);
    reg_write(3'd6, 5'd0, 3'd0, 8'h00);
    read_check("R8 slot 0 visible again", 3'd4, 5'd7, 3'd0, 8'hF3);
    read_check("R8 write was ignored", 3'd5, 5'd7, 3'd0, 8'hC7);
    compare(4'd7, ADR_G, 1'b1, "R8 slot intact");

    // R9 hold between strobes
    compare(4'd0, ADR_B, 1'b1, "R9 setup hit");
    drain();
    repeat (3) @(negedge clk);
    n_checks++;
    if (hit !== 1'b1) begin
      n_fail++;
      $display("FAIL R9 hold: actual %0b expected 1", hit);
    end

    // R9 compare uses state before a same-cycle write
    @(negedge clk);
    exp_q.push_back(1'b1); tag_q.push_back("R9 old state in write cycle");
    cmp_port = 4'd12; cmp_addr = ADR_B; cmp_valid = 1'b1;
    reg_space = 3'd3; reg_idx = 5'd3; reg_wdata = 8'h00; reg_wr = 1'b1;
    @(negedge clk);
    cmp_valid = 1'b0; reg_wr = 1'b0;
    compare(4'd12, ADR_B, 1'b0, "R9 write visible afterwards");

    drain();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule